// File: doc/BRIEF.md
# Hash-Based Request Acceptance Filter

Several nodes of a group all receive one broadcast stream of requests. Each node runs this filter on its copy of the stream. The filter reduces the source address of every request to a small bucket number by hashing it. The request goes on to the node's output only when that bucket belongs to the node. Requests for any other bucket are taken off the input and discarded, so each node handles only its own share of the traffic.

Bucket ownership is a bit mask held in a configuration register. When a peer fails, the surviving nodes are given new masks that cover the failed node's buckets, and traffic is spread again without a central distributor. Two counters, one for forwarded requests and one for discarded requests, can be read through the same configuration port.

Top module: `hash_accept_filter`

## Requirements
- R1: The bucket of a request is the XOR of all BKT_W-bit slices of its source address. With the defaults, that is the XOR of the eight 4-bit nibbles of a 32-bit address, which gives 16 buckets.
- R2: A request whose bucket bit is set in the ownership mask is forwarded with its address and data unchanged. out_valid rises on the clock edge that completes the input handshake.
- R3: A request whose bucket bit is clear never appears at the output. in_ready is high for it in the same cycle, even while the output is stalled.
- R4: While out_valid is high and out_ready is low, out_valid, out_addr and out_data stay unchanged.
- R5: A write to configuration register 0 replaces the mask with the low NBKT bits of cfg_wdata. A request handshaken in the write cycle is judged against the old mask, and any later request is judged against the new one.
- R6: Configuration register 1 reads the count of forwarded requests and register 2 reads the count of discarded requests. Each counter rises by one per handshake of its kind and wraps at CNT_W bits.
- R7: After reset, out_valid is 0, both counters are 0 and the mask equals the RST_MASK parameter.
- R8: Writes to configuration registers 1, 2 and 3 change nothing. Register 3 reads as 0.
- R9: in_ready is high whenever the output register is empty or out_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming request present |
| in_ready | output | 1 | Request taken this cycle |
| in_addr | input | ADDR_W | Source address of the request |
| in_data | input | DATA_W | Request payload |
| out_valid | output | 1 | Forwarded request present |
| out_ready | input | 1 | Downstream takes the request |
| out_addr | output | ADDR_W | Source address of the forwarded request |
| out_data | output | DATA_W | Payload of the forwarded request |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 mask, 1 forwarded count, 2 discarded count, 3 reserved |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data of the selected register |

## Verification
The bench uses the default parameters: a 32-bit address folded into 4 bits, 16 buckets, 32-bit counters and an empty mask at reset. With 16 buckets, a random mask and random addresses reach every bucket many times in a few thousand requests. A random out_ready keeps the output stalled often, so discarded requests arrive behind a held output. Mask writes fall in the same cycle as handshakes by chance as well as in directed cases. Directed cases also fix the fold of a known address and check that writes to the counter registers have no effect.

// File: rtl/hash_accept_filter.sv
module hash_accept_filter #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BKT_W = 4,
  parameter int CNT_W = 32,
  parameter logic [(1<<BKT_W)-1:0] RST_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);
  localparam int NBKT = 1 << BKT_W;
  localparam int FOLDS = ADDR_W / BKT_W;
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [NBKT-1:0]  mask_q;
  logic [CNT_W-1:0] fwd_q, drop_q;
  logic [BKT_W-1:0] bkt;
  logic             own, fire;

  always_comb begin
    bkt = '0;
    for (int i = 0; i < FOLDS; i++) bkt = bkt ^ in_addr[i*BKT_W +: BKT_W];
  end

  assign own      = mask_q[bkt];
  assign in_ready = !out_valid || out_ready || !own;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fire && own) begin
        out_valid <= 1'b1;
        out_addr  <= in_addr;
        out_data  <= in_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= RST_MASK;
      fwd_q  <= '0;
      drop_q <= '0;
    end else begin
      if (cfg_wr && cfg_sel == 2'd0) mask_q <= cfg_wdata[NBKT-1:0];
      if (fire && own)  fwd_q  <= fwd_q + ONE;
      if (fire && !own) drop_q <= drop_q + ONE;
    end
  end

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = 32'(mask_q);
      2'd1:    cfg_rdata = 32'(fwd_q);
      2'd2:    cfg_rdata = 32'(drop_q);
      default: cfg_rdata = '0;
    endcase
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && own |=> out_valid && out_addr == $past(in_addr) && out_data == $past(in_data));
  p_drop_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !own |-> in_ready);
  p_drop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && in_valid && !own |=> !out_valid);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data));
  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_sel == 2'd0 |=> mask_q == $past(cfg_wdata[NBKT-1:0]));
  p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(fwd_q) && $stable(drop_q));
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);
endmodule

// File: tb/hash_accept_filter_test.sv
`timescale 1ns/1ps
module hash_accept_filter_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, cfg_wr = 0;
  logic [31:0] in_addr = 0, in_data = 0, cfg_wdata = 0;
  logic [1:0] cfg_sel = 0;
  logic in_ready, out_valid;
  logic [31:0] out_addr, out_data, cfg_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_mask;
  logic m_ov;
  logic [31:0] m_oa, m_od, m_fwd, m_drop;

  always #2.5 clk = ~clk;

  hash_accept_filter uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

  function automatic logic [3:0] fold(input logic [31:0] a);
    logic [3:0] b = 0;
    for (int i = 0; i < 8; i++) b ^= a[4*i +: 4];
    return b;
  endfunction

  function automatic logic [31:0] reg_val(input logic [1:0] s);
    case (s)
      2'd0: return {16'h0, m_mask};
      2'd1: return m_fwd;
      2'd2: return m_drop;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] d, input logic ordy,
                      input logic wr, input logic [1:0] sel, input logic [31:0] wd);
    logic own, rdy;
    @(negedge clk);
    chk("R2/R3/R4 out_valid", {31'h0, out_valid}, {31'h0, m_ov});
    if (m_ov) begin
      chk("R2/R4 out_addr", out_addr, m_oa);
      chk("R2/R4 out_data", out_data, m_od);
    end
    in_valid = v; in_addr = a; in_data = d; out_ready = ordy;
    cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd;
    #1;
    own = m_mask[fold(a)];
    rdy = !m_ov || ordy || !own;
    chk("R3/R9 in_ready", {31'h0, in_ready}, {31'h0, rdy});
    chk("R6/R8 cfg_rdata", cfg_rdata, reg_val(sel));
    if (m_ov && ordy) m_ov = 0;
    if (v && rdy && own) begin m_ov = 1; m_oa = a; m_od = d; m_fwd++; end
    if (v && rdy && !own) m_drop++;
    if (wr && sel == 2'd0) m_mask = wd[15:0];
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 out_valid at reset", {31'h0, out_valid}, 32'h0);
    for (int s = 0; s < 4; s++) begin
      cfg_sel = s[1:0]; #1;
      chk("R7 registers at reset", cfg_rdata, 32'h0);
    end
    rst_n = 1;
    m_mask = 0; m_ov = 0; m_oa = 0; m_od = 0; m_fwd = 0; m_drop = 0;

    // R3: empty mask, stalled output, every request dropped and acknowledged
    for (int i = 0; i < 20; i++) step(1, $urandom, $urandom, 0, 0, 2'd2, 0);
    // R1: 0x12345678 folds to bucket 8, 0x12345679 to bucket 9
    step(0, 0, 0, 0, 1, 2'd0, 32'h0000_0100);
    step(1, 32'h1234_5678, 32'hA5A5_0001, 0, 0, 2'd1, 0);
    step(1, 32'h1234_5679, 32'hA5A5_0002, 0, 0, 2'd2, 0);
    step(0, 0, 0, 1, 0, 2'd1, 0);
    // R5: request in the same cycle as a mask change uses the old mask
    step(1, 32'h1234_5679, 32'hA5A5_0003, 1, 1, 2'd0, 32'h0000_0200);
    step(1, 32'h1234_5679, 32'hA5A5_0004, 1, 0, 2'd0, 0);
    // R8: writes to counters and reserved register have no effect
    step(0, 0, 0, 1, 1, 2'd1, 32'hFFFF_FFFF);
    step(0, 0, 0, 1, 1, 2'd2, 32'hFFFF_FFFF);
    step(0, 0, 0, 1, 1, 2'd3, 32'hFFFF_FFFF);
    step(0, 0, 0, 1, 0, 2'd1, 0);
    step(0, 0, 0, 1, 0, 2'd2, 0);
    step(0, 0, 0, 1, 0, 2'd3, 0);
    // R2/R4/R6/R9 random traffic with occasional remapping
    for (int i = 0; i < 4000; i++) begin
      logic wr = ($urandom % 16) == 0;
      step($urandom % 4 != 0, $urandom, $urandom, $urandom % 3 != 0,
           wr, wr ? (($urandom % 4 == 0) ? 2'($urandom) : 2'd0) : 2'($urandom), $urandom);
    end
    step(0, 0, 0, 1, 0, 2'd1, 0);
    step(0, 0, 0, 1, 0, 2'd2, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule